// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot capability, slot control and slot status registers of a hot-plug capable downstream or root port. Software reaches them through a 32-bit configuration port with byte enables. Dword 0 holds the read-only capability word. Dword 1 carries the control half-word in bits 15:0 and the status half-word in bits 31:16. The slot side raises events into the status half-word: an attention button press, a runtime insertion and a removal request. A boot-time presence input sets the initial presence state when reset is applied.

From the combined control and status state the block derives a single notification level. When that level changes, the block either raises a one-cycle message request carrying a 5-bit vector or drives a level INTx output. The choice comes from the MSI-X and MSI enable inputs. Every write to the control half-word is one command and completes on the next cycle. When the written value turns the slot off while a device is present, the block pulses a detach request.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After synchronous reset the control half-word has the hot-plug, command-completed, presence-changed and button enables cleared, and the attention indicator (bits 7:6) set to the off code 11. The status half-word has interlock status (bit 7), command completed (bit 4), presence changed (bit 3) and button pressed (bit 0) cleared. Presence state (bit 6) equals the boot presence input.
- R2: When power control is present (the default), reset sets power controller control (bit 10) to 0 and the power indicator (bits 9:8) to on (01) if a device is present at boot. With no device present it sets bit 10 to 1 and bits 9:8 to off (11).
- R3: Status bits 0, 3 and 4 clear when 1 is written to them: dword 1, bits 16, 19 and 20, byte lane 2. Writes have no effect on presence state and interlock status.
- R4: Any write to dword 1 with byte enable 0 or 1 set sets command completed one cycle later. This holds even when the same write clears that bit.
- R5: Writing 1 to the interlock control bit (bit 11, byte lane 1) toggles interlock status. Bit 11 always reads back as 0.
- R6: A control write with byte lane 1 enabled, bit 10 = 1 and bits 9:8 = 11, made while presence state is 1, pulses `detach_o`, clears presence state and sets presence changed. With presence state 0 it does not pulse.
- R7: The notification level is the hot-plug enable (bit 5) ANDed with any of status bits 0, 3 and 4 whose enable at the same control bit position is set. With both message enables low, `intx_o` follows this level two cycles after the stimulus.
- R8: With MSI-X or MSI enabled, a rising notification level gives a one-cycle `msg_req_o` carrying `msg_num_i` on `msg_vec_o`, and `intx_o` stays low. MSI-X takes precedence over MSI. A falling level sends no message.
- R9: Raising an event whose status bit is already set gives no new message.
- R10: A runtime insertion sets presence state, presence changed and button pressed. An attention button press sets button pressed. A removal request sets button pressed.
- R11: An insertion or removal request while interlock status is 1 pulses `busy_o` and leaves the status half-word unchanged.
- R12: Reads return data one cycle after the address. Dword 0 reads 0x002A007B with the default slot number 5: slot number in bits 31:19, and bits 17, 6, 5, 4, 3, 1 and 0 set. Unmapped addresses read 0.
- R13: A status write that clears the last enabled pending event drops the notification level and deasserts `intx_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_present_i | input | 1 | Device present when reset is applied |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Dword index |
| cfg_be_i | input | 4 | Byte enables |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Registered read data |
| attn_btn_i | input | 1 | Attention button press pulse |
| insert_i | input | 1 | Runtime insertion pulse |
| remove_i | input | 1 | Removal request pulse |
| msix_en_i | input | 1 | MSI-X enabled |
| msi_en_i | input | 1 | MSI enabled |
| msg_num_i | input | 5 | Interrupt message number |
| msg_req_o | output | 1 | One-cycle message request |
| msg_vec_o | output | 5 | Vector of the message request |
| intx_o | output | 1 | Level interrupt |
| detach_o | output | 1 | Detach request pulse |
| busy_o | output | 1 | Request rejected, slot locked |

## Verification
A wrong status or control bit appears in the dword 1 read data one cycle after the address is presented. It also shows up two cycles after the stimulus as a wrong `intx_o` level or a missing or extra message pulse. A notification level stuck high hides later events, so the bench counts message pulses rather than sampling levels. A wrong interlock state appears as `busy_o` pulses on the next request, or as a missing detach pulse.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  // control half-word fields
  localparam int C_ABPE = 0;
  localparam int C_PDCE = 3;
  localparam int C_CCIE = 4;
  localparam int C_HPIE = 5;
  localparam int C_PCC  = 10;
  localparam int C_EIC  = 11;
  // status half-word fields
  localparam int S_ABP = 0;
  localparam int S_PDC = 3;
  localparam int S_CC  = 4;
  localparam int S_PDS = 6;
  localparam int S_EIS = 7;

  localparam logic [1:0] IND_ON    = 2'b01;
  localparam logic [1:0] IND_BLINK = 2'b10;
  localparam logic [1:0] IND_OFF   = 2'b11;

  // supported events; enables sit at the same bit positions in control
  localparam logic [15:0] EVT_MASK = 16'h0019;

  typedef enum logic [1:0] {IRQ_INTX, IRQ_MSI, IRQ_MSIX} irq_mode_e;

  function automatic logic [31:0] slot_cap_word(input logic [12:0] num, input logic pwr);
    logic [31:0] w;
    w        = '0;
    w[31:19] = num;
    w[17]    = 1'b1;  // interlock present
    w[6]     = 1'b1;  // hot-plug capable
    w[5]     = 1'b1;  // hot-plug surprise
    w[4]     = 1'b1;  // power indicator present
    w[3]     = 1'b1;  // attention indicator present
    w[1]     = pwr;   // power controller present
    w[0]     = 1'b1;  // attention button present
    return w;
  endfunction
endpackage

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_slot_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int SLOT_ADDR = 1,
  parameter bit HAS_PWR   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_present_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  input  logic              attn_btn_i,
  input  logic              insert_i,
  input  logic              remove_i,
  output logic [15:0]       ctl_o,
  output logic [15:0]       sts_o,
  output logic              detach_o,
  output logic              busy_o
);
  localparam logic [15:0] CTL_WMASK = 16'h03F9 | (HAS_PWR ? 16'h0400 : 16'h0000);

  logic [15:0] ctl_q, sts_q, ctl_d, sts_d;
  logic [15:0] ctl_bm, sts_bm, sts_clr, sts_set;
  logic        wr_slot, ctl_hit, sts_hit, eic_tog, locked;
  logic        ins_ok, rem_ok, busy_d, detach_d;

  function automatic logic [15:0] ctl_reset(input logic present);
    logic [15:0] c;
    c      = '0;
    c[7:6] = IND_OFF;
    if (HAS_PWR) begin
      c[9:8]   = present ? IND_ON : IND_OFF;
      c[C_PCC] = ~present;
    end else begin
      c[9:8]   = IND_OFF;
    end
    return c;
  endfunction

  always_comb begin
    wr_slot  = wr_i && (addr_i == ADDR_W'(SLOT_ADDR));
    ctl_hit  = wr_slot && (|be_i[1:0]);
    sts_hit  = wr_slot && (|be_i[3:2]);
    ctl_bm   = {{8{be_i[1]}}, {8{be_i[0]}}} & CTL_WMASK;
    sts_bm   = {{8{be_i[3]}}, {8{be_i[2]}}} & EVT_MASK;
    eic_tog  = wr_slot && be_i[1] && wdata_i[C_EIC];
    locked   = sts_q[S_EIS];
    ins_ok   = insert_i && !locked;
    rem_ok   = remove_i && !locked;
    busy_d   = (insert_i || remove_i) && locked;
    detach_d = ctl_hit && be_i[1] && sts_q[S_PDS] && wdata_i[C_PCC] &&
               (wdata_i[9:8] == IND_OFF);

    ctl_d = ctl_q;
    if (ctl_hit) ctl_d = (ctl_q & ~ctl_bm) | (wdata_i[15:0] & ctl_bm);

    sts_clr = sts_hit ? (wdata_i[31:16] & sts_bm) : 16'h0000;
    sts_set = '0;
    sts_set[S_ABP] = attn_btn_i || ins_ok || rem_ok;
    sts_set[S_PDC] = ins_ok || detach_d;
    sts_set[S_CC]  = ctl_hit;
    // a new event wins over a clear in the same cycle
    sts_d = (sts_q & ~sts_clr) | sts_set;
    sts_d[S_PDS] = ins_ok ? 1'b1 : (detach_d ? 1'b0 : sts_q[S_PDS]);
    sts_d[S_EIS] = sts_q[S_EIS] ^ eic_tog;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q        <= ctl_reset(boot_present_i);
      sts_q        <= '0;
      sts_q[S_PDS] <= boot_present_i;
      detach_o     <= 1'b0;
      busy_o       <= 1'b0;
    end else begin
      ctl_q    <= ctl_d;
      sts_q    <= sts_d;
      detach_o <= detach_d;
      busy_o   <= busy_d;
    end
  end

  assign ctl_o = ctl_q;
  assign sts_o = sts_q;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctl_q[7:6] == IND_OFF) && !ctl_q[C_HPIE] && !sts_q[S_EIS] &&
                   !sts_q[S_CC] && (sts_q[S_PDS] == $past(boot_present_i)));

  assert_cc_after_ctl_write_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == ADDR_W'(SLOT_ADDR) && (|be_i[1:0])) |=> sts_q[S_CC]);

  assert_eis_toggle_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == ADDR_W'(SLOT_ADDR) && be_i[1] && wdata_i[C_EIC])
      |=> (sts_q[S_EIS] != $past(sts_q[S_EIS])));

  assert_detach_sets_pdc_R6: assert property (@(posedge clk) disable iff (rst)
    detach_o |-> sts_q[S_PDC]);

  assert_busy_only_locked_R11: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> $past(sts_q[S_EIS]) && $stable(sts_q[S_PDS]));
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
  import hp_slot_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [15:0]      ctl_i,
  input  logic [15:0]      sts_i,
  input  logic             msix_en_i,
  input  logic             msi_en_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             msg_req_o,
  output logic [VEC_W-1:0] msg_vec_o,
  output logic             intx_o
);
  logic      pend, pend_q;
  irq_mode_e mode;

  always_comb begin
    pend = ctl_i[C_HPIE] && (|(ctl_i & sts_i & EVT_MASK));
    if (msix_en_i)     mode = IRQ_MSIX;
    else if (msi_en_i) mode = IRQ_MSI;
    else               mode = IRQ_INTX;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      msg_req_o <= 1'b0;
      msg_vec_o <= '0;
      intx_o    <= 1'b0;
    end else begin
      pend_q    <= pend;
      msg_req_o <= pend && !pend_q && (mode != IRQ_INTX);
      if (pend && !pend_q && (mode != IRQ_INTX)) msg_vec_o <= vec_i;
      intx_o    <= pend && (mode == IRQ_INTX);
    end
  end

  assert_msg_on_rise_R8: assert property (@(posedge clk) disable iff (rst)
    msg_req_o |-> pend_q && !$past(pend_q));

  assert_intx_mode_R7: assert property (@(posedge clk) disable iff (rst)
    intx_o |-> $past(!msi_en_i && !msix_en_i));
endmodule

// File: rtl/hp_slot_rdmux.sv
module hp_slot_rdmux
  import hp_slot_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CAP_ADDR  = 0,
  parameter int SLOT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       cap_i,
  input  logic [15:0]       ctl_i,
  input  logic [15:0]       sts_i,
  output logic [31:0]       rdata_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (addr_i == ADDR_W'(CAP_ADDR)) begin
      rdata_o <= cap_i;
    end else if (addr_i == ADDR_W'(SLOT_ADDR)) begin
      rdata_o <= {sts_i, ctl_i};
    end else begin
      rdata_o <= '0;
    end
  end

  assert_eic_reads_zero_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(addr_i) == ADDR_W'(SLOT_ADDR)) |-> (rdata_o[C_EIC] == 1'b0));
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter int          CAP_ADDR  = 0,
  parameter int          SLOT_ADDR = 1,
  parameter int          VEC_W     = 5,
  parameter logic [12:0] SLOT_NUM  = 13'd5,
  parameter bit          HAS_PWR   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_present_i,
  input  logic              cfg_wr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [3:0]        cfg_be_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              attn_btn_i,
  input  logic              insert_i,
  input  logic              remove_i,
  input  logic              msix_en_i,
  input  logic              msi_en_i,
  input  logic [VEC_W-1:0]  msg_num_i,
  output logic              msg_req_o,
  output logic [VEC_W-1:0]  msg_vec_o,
  output logic              intx_o,
  output logic              detach_o,
  output logic              busy_o
);
  localparam logic [31:0] CAP_WORD = slot_cap_word(SLOT_NUM, HAS_PWR);

  logic [15:0] ctl, sts;

  hp_slot_regs #(.ADDR_W(ADDR_W), .SLOT_ADDR(SLOT_ADDR), .HAS_PWR(HAS_PWR)) u_regs (
    .clk(clk), .rst(rst), .boot_present_i(boot_present_i),
    .wr_i(cfg_wr_i), .addr_i(cfg_addr_i), .be_i(cfg_be_i), .wdata_i(cfg_wdata_i),
    .attn_btn_i(attn_btn_i), .insert_i(insert_i), .remove_i(remove_i),
    .ctl_o(ctl), .sts_o(sts), .detach_o(detach_o), .busy_o(busy_o)
  );

  hp_slot_notify #(.VEC_W(VEC_W)) u_notify (
    .clk(clk), .rst(rst), .ctl_i(ctl), .sts_i(sts),
    .msix_en_i(msix_en_i), .msi_en_i(msi_en_i), .vec_i(msg_num_i),
    .msg_req_o(msg_req_o), .msg_vec_o(msg_vec_o), .intx_o(intx_o)
  );

  hp_slot_rdmux #(.ADDR_W(ADDR_W), .CAP_ADDR(CAP_ADDR), .SLOT_ADDR(SLOT_ADDR)) u_rdmux (
    .clk(clk), .rst(rst), .addr_i(cfg_addr_i), .cap_i(CAP_WORD),
    .ctl_i(ctl), .sts_i(sts), .rdata_o(cfg_rdata_o)
  );
endmodule

// File: tb/tb_hp_slot_ctrl.sv
`timescale 1ns/1ps
module tb_hp_slot_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boot_present = 1'b1;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        attn = 1'b0, ins = 1'b0, rem = 1'b0;
  logic        msix_en = 1'b0, msi_en = 1'b0;
  logic [4:0]  vec = '0;
  logic        msg_req, intx, detach, busy;
  logic [4:0]  msg_vec;

  int checks = 0, fails = 0;
  int msg_cnt = 0, detach_cnt = 0, busy_cnt = 0;
  logic [4:0] last_vec = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hp_slot_ctrl dut (
    .clk(clk), .rst(rst), .boot_present_i(boot_present),
    .cfg_wr_i(wr), .cfg_addr_i(addr), .cfg_be_i(be), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .attn_btn_i(attn), .insert_i(ins), .remove_i(rem),
    .msix_en_i(msix_en), .msi_en_i(msi_en), .msg_num_i(vec),
    .msg_req_o(msg_req), .msg_vec_o(msg_vec), .intx_o(intx),
    .detach_o(detach), .busy_o(busy)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (msg_req) begin msg_cnt++; last_vec = msg_vec; end
      if (detach) detach_cnt++;
      if (busy) busy_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic present);
    @(negedge clk); rst = 1'b1; boot_present = present;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; be = b; wdata = d;
    @(negedge clk); wr = 1'b0; be = '0;
  endtask

  task automatic cfg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic ev_pulse(input int which);
    @(negedge clk);
    case (which) 0: attn = 1'b1; 1: ins = 1'b1; default: rem = 1'b1; endcase
    @(negedge clk); attn = 1'b0; ins = 1'b0; rem = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_present();
    logic [31:0] d;
    do_reset(1'b1);
    chk("R1 intx after reset", {31'b0, intx}, 0);
    chk("R1 msg after reset", {31'b0, msg_req}, 0);
    cfg_read(4'd1, d); chk("R1 R2 slot word, present", d, 32'h0040_01C0);
    cfg_read(4'd0, d); chk("R12 capability word", d, 32'h002A_007B);
    cfg_read(4'd2, d); chk("R12 unmapped read", d, 32'h0);
  endtask

  task automatic t_reset_absent();
    logic [31:0] d;
    do_reset(1'b0);
    cfg_read(4'd1, d); chk("R2 slot word, absent", d, 32'h0000_07C0);
  endtask

  task automatic t_enable_intx();
    logic [31:0] d;
    cfg_write(4'd1, 4'b0011, 32'h0000_07F9);
    settle();
    chk("R7 intx follows pending", {31'b0, intx}, 1);
    cfg_read(4'd1, d); chk("R4 command completed set", d, 32'h0010_07F9);
    cfg_write(4'd1, 4'b0100, 32'h00D0_0000);
    settle();
    chk("R13 intx drops after clear", {31'b0, intx}, 0);
    cfg_read(4'd1, d); chk("R3 event cleared", d, 32'h0000_07F9);
  endtask

  task automatic t_insert();
    logic [31:0] d;
    ev_pulse(1);
    settle();
    chk("R10 insertion raises intx", {31'b0, intx}, 1);
    cfg_read(4'd1, d); chk("R10 insertion status", d, 32'h0049_07F9);
    cfg_write(4'd1, 4'b0100, 32'h00FF_0000);
    settle();
    cfg_read(4'd1, d); chk("R3 presence kept on clear", d, 32'h0040_07F9);
    chk("R13 intx low", {31'b0, intx}, 0);
  endtask

  task automatic t_messages();
    msi_en = 1'b1; vec = 5'd19;
    ev_pulse(0); settle();
    chk("R8 msi message count", msg_cnt, 1);
    chk("R8 msi vector", {27'b0, last_vec}, 19);
    chk("R8 no intx in msi mode", {31'b0, intx}, 0);
    ev_pulse(0); settle();
    chk("R9 repeated event no message", msg_cnt, 1);
    cfg_write(4'd1, 4'b0100, 32'h0001_0000); settle();
    chk("R8 no message on falling", msg_cnt, 1);
    msix_en = 1'b1; vec = 5'd7;
    ev_pulse(0); settle();
    chk("R8 msix message count", msg_cnt, 2);
    chk("R8 msix vector", {27'b0, last_vec}, 7);
    cfg_write(4'd1, 4'b0100, 32'h0001_0000); settle();
    msix_en = 1'b0; msi_en = 1'b0;
  endtask

  task automatic t_interlock();
    logic [31:0] d;
    cfg_write(4'd1, 4'b0010, 32'h0000_0B00); settle();
    cfg_read(4'd1, d); chk("R5 interlock set, control bit reads 0", d, 32'h00D0_03F9);
    chk("R7 intx from command completed", {31'b0, intx}, 1);
    cfg_write(4'd1, 4'b0100, 32'h0010_0000);
    ev_pulse(1); ev_pulse(2); settle();
    chk("R11 busy pulses", busy_cnt, 2);
    cfg_read(4'd1, d); chk("R11 status unchanged when locked", d, 32'h00C0_03F9);
    cfg_write(4'd1, 4'b0010, 32'h0000_0B00); settle();
    cfg_read(4'd1, d); chk("R5 interlock toggled off", d, 32'h0050_03F9);
    ev_pulse(2); settle();
    chk("R11 no busy when unlocked", busy_cnt, 2);
    cfg_read(4'd1, d); chk("R10 removal sets button pressed", d, 32'h0051_03F9);
  endtask

  task automatic t_detach();
    logic [31:0] d;
    cfg_write(4'd1, 4'b0010, 32'h0000_0700); settle();
    chk("R6 detach pulse", detach_cnt, 1);
    cfg_read(4'd1, d); chk("R6 presence cleared, changed set", d, 32'h0019_07F9);
    cfg_write(4'd1, 4'b0010, 32'h0000_0700); settle();
    chk("R6 no detach when empty", detach_cnt, 1);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    cfg_write(4'd1, 4'b0101, 32'h0010_00F9); settle();
    cfg_read(4'd1, d); chk("R4 completion survives same-write clear", d, 32'h0019_07F9);
    cfg_write(4'd1, 4'b0100, 32'h0019_0000); settle();
    cfg_read(4'd1, d); chk("R3 all events cleared", d, 32'h0000_07F9);
    chk("R13 intx deasserted", {31'b0, intx}, 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    t_reset_present();
    t_reset_absent();
    t_enable_intx();
    t_insert();
    t_messages();
    t_interlock();
    t_detach();
    t_set_wins();
    done = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule